// File: doc/BRIEF.md
# Sector Hamming ECC checker

This block judges one 512-byte sector after a flash read. It takes two 24-bit Hamming codes. One is the code that was stored in the spare area when the page was written. The other is the code that the datapath computed over the sector as it was read back. The block folds both codes into a 28-bit layout that has gaps in it, and XORs them to form a syndrome. From the syndrome it decides whether the sector is clean, holds one flipped data bit that can be repaired, holds damage in the stored code only, or cannot be repaired. A freshly erased page reads back as all ones while its computed code is zero. The block recognises this case so that it does not raise a false error.

A caller presents both codes together with a one-cycle `start` strobe. One clock later the verdict appears on `res_status` and `res_byte`/`res_bit`, marked by a single-cycle `res_valid` pulse. The result has no back-pressure. `res_valid` is a plain pulse and cannot be stalled. The verdict stays on the outputs until the next `start`, so a consumer that misses the pulse can still read it. `start` may be held high on consecutive cycles, and each such cycle yields its own verdict one cycle later.

The block only classifies and locates the error. Computing the code over the data and flipping the bit in the buffer belong to neighbouring logic.

Top module: `ecc_sector_checker`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `start`, `res_valid` is 0, `res_status` is 00, and `res_byte` and `res_bit` are 0.
- R2: A `start` sampled high at a rising edge makes `res_valid` high for the cycle that follows that edge. A cycle without `start` leaves `res_valid` low. Back-to-back starts give back-to-back verdicts.
- R3: Each code is read with byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. It is repacked into a 28-bit word: byte 0 goes to bits 7:0, byte 1 to bits 23:16, the low nibble of byte 2 to bits 11:8 and the high nibble of byte 2 to bits 27:24, with bits 15:12 zero. The syndrome is the XOR of the two packed words. A zero syndrome gives status 00 (clean).
- R4: A syndrome with exactly 12 bits set gives status 01 (repairable data bit). `res_byte` is then syndrome bits 27:19 (byte 0..511) and `res_bit` is syndrome bits 18:16.
- R5: A syndrome with exactly one bit set gives status 10 (stored code damaged).
- R6: A stored code whose packed word is 0x0FFF0FFF (all three bytes 0xFF) together with a computed code of zero is an erased page and gives status 00.
- R7: Any other nonzero syndrome gives status 11 (unrepairable). This covers two-bit errors and the erased pattern with the roles of the two codes swapped.
- R8: `res_byte` and `res_bit` are zero whenever `res_status` is not 01.
- R9: Between starts, the outputs `res_status`, `res_byte` and `res_bit` hold their values. Changes on the code inputs while `start` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe: evaluate the codes now |
| stored_ecc | input | 24 | Code read from the spare area, byte 0 in bits 7:0 |
| computed_ecc | input | 24 | Code computed over the sector data, same byte order |
| res_valid | output | 1 | Pulses for one cycle when a new verdict is present |
| res_status | output | 2 | 00 clean, 01 repairable, 10 code damaged, 11 unrepairable |
| res_byte | output | 9 | Byte index of the flipped data bit |
| res_bit | output | 3 | Bit index within that byte |

## Verification
The checks assume that `stored_ecc` and `computed_ecc` are stable and known in every cycle where `start` is high. They also assume that the repacking is a pure permutation of bits, so a popcount over the raw 24-bit XOR equals the popcount over the packed syndrome. The properties relate the bit count of the raw input XOR, and the erased pattern, to the status one cycle later. The directed stimulus drives codes only at falling edges and always pairs them with a deliberate `start` level. Data-error cases are built from a location and its complement, so every syndrome is well formed.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  localparam int SECTOR_BYTES = 512;
  localparam int CODE_W       = 24;
  localparam int PACK_W       = 28;
  localparam int BIT_W        = $clog2(8);
  localparam int BYTE_W       = $clog2(SECTOR_BYTES);
  localparam int LOC_W        = BIT_W + BYTE_W;
  localparam int LOC_LSB      = 16;
  localparam int CNT_W        = $clog2(PACK_W + 1);
  localparam int CODE_COUNT   = 2;

  localparam logic [PACK_W-1:0] BLANK_STORED = 28'h0FFF0FFF;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_FIXABLE  = 2'b01,
    ST_CODE_BAD = 2'b10,
    ST_FATAL    = 2'b11
  } chk_status_e;
endpackage

// File: rtl/ecc_chk_repack.sv
module ecc_chk_repack
  import ecc_chk_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [PACK_W-1:0] word
);
  // Fold three code bytes into the gapped 28-bit layout.
  logic [7:0] b0, b1, b2;
  assign b0 = code[7:0];
  assign b1 = code[15:8];
  assign b2 = code[23:16];

  assign word = {b2[7:4], b1, 4'b0000, b2[3:0], b0};
endmodule

// File: rtl/ecc_chk_popcount.sv
module ecc_chk_popcount #(
  parameter int W   = 28,
  parameter int CW  = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/ecc_chk_classify.sv
module ecc_chk_classify
  import ecc_chk_pkg::*;
(
  input  logic [PACK_W-1:0] stored_w,
  input  logic [PACK_W-1:0] fresh_w,
  output chk_status_e       verdict,
  output logic [BYTE_W-1:0] loc_byte,
  output logic [BIT_W-1:0]  loc_bit
);
  localparam int PAIRS = LOC_W;

  logic [PACK_W-1:0] syn;
  logic [CNT_W-1:0]  weight;
  logic              blank_page;

  assign syn        = stored_w ^ fresh_w;
  assign blank_page = (stored_w == BLANK_STORED) && (fresh_w == '0);

  ecc_chk_popcount #(.W(PACK_W), .CW(CNT_W)) u_weight (
    .vec  (syn),
    .ones (weight)
  );

  // Priority: clean, single data bit, single code bit, erased page, rest.
  always_comb begin
    verdict  = ST_FATAL;
    loc_byte = '0;
    loc_bit  = '0;
    if (syn == '0) begin
      verdict = ST_CLEAN;
    end else if (weight == CNT_W'(PAIRS)) begin
      verdict  = ST_FIXABLE;
      loc_bit  = syn[LOC_LSB +: BIT_W];
      loc_byte = syn[LOC_LSB + BIT_W +: BYTE_W];
    end else if (weight == CNT_W'(1)) begin
      verdict = ST_CODE_BAD;
    end else if (blank_page) begin
      verdict = ST_CLEAN;
    end
  end
endmodule

// File: rtl/ecc_sector_checker.sv
module ecc_sector_checker
  import ecc_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] stored_ecc,
  input  logic [CODE_W-1:0] computed_ecc,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [BYTE_W-1:0] res_byte,
  output logic [BIT_W-1:0]  res_bit
);
  logic [CODE_W-1:0] codes  [CODE_COUNT];
  logic [PACK_W-1:0] packed_w [CODE_COUNT];

  assign codes[0] = stored_ecc;
  assign codes[1] = computed_ecc;

  for (genvar g = 0; g < CODE_COUNT; g++) begin : g_pack
    ecc_chk_repack u_repack (
      .code (codes[g]),
      .word (packed_w[g])
    );
  end

  chk_status_e       nx_status;
  logic [BYTE_W-1:0] nx_byte;
  logic [BIT_W-1:0]  nx_bit;

  ecc_chk_classify u_cls (
    .stored_w (packed_w[0]),
    .fresh_w  (packed_w[1]),
    .verdict  (nx_status),
    .loc_byte (nx_byte),
    .loc_bit  (nx_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= ST_CLEAN;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_status <= nx_status;
        res_byte   <= nx_byte;
        res_bit    <= nx_bit;
      end
    end
  end
endmodule

// File: rtl/ecc_sector_checker_sva.sv
module ecc_sector_checker_sva
  import ecc_chk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] stored_ecc,
  input logic [CODE_W-1:0] computed_ecc,
  input logic              res_valid,
  input logic [1:0]        res_status,
  input logic [BYTE_W-1:0] res_byte,
  input logic [BIT_W-1:0]  res_bit
);
  assert_pulse_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);

  assert_no_pulse_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid);

  assert_equal_codes_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stored_ecc == computed_ecc) |=> res_status == 2'b00);

  assert_twelve_bits_fixable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $countones(stored_ecc ^ computed_ecc) == 12) |=> res_status == 2'b01);

  assert_one_bit_code_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $countones(stored_ecc ^ computed_ecc) == 1) |=> res_status == 2'b10);

  assert_erased_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stored_ecc == 24'hFFFFFF && computed_ecc == 24'h000000) |=> res_status == 2'b00);

  assert_two_bits_fatal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $countones(stored_ecc ^ computed_ecc) == 2) |=> res_status == 2'b11);

  assert_loc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_status != 2'b01) |-> (res_byte == '0 && res_bit == '0));

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(res_status) && $stable(res_byte) && $stable(res_bit)));
endmodule

bind ecc_sector_checker ecc_sector_checker_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .stored_ecc   (stored_ecc),
  .computed_ecc (computed_ecc),
  .res_valid    (res_valid),
  .res_status   (res_status),
  .res_byte     (res_byte),
  .res_bit      (res_bit)
);

// File: tb/sim_ecc_sector_checker.sv
`timescale 1ns/1ps
module sim_ecc_sector_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] stored_i = '0;
  logic [23:0] computed_i = '0;
  logic        v_o;
  logic [1:0]  st_o;
  logic [8:0]  byte_o;
  logic [2:0]  bit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ecc_sector_checker u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start_i),
    .stored_ecc   (stored_i),
    .computed_ecc (computed_i),
    .res_valid    (v_o),
    .res_status   (st_o),
    .res_byte     (byte_o),
    .res_bit      (bit_o)
  );

  function automatic logic [27:0] pack28(input logic [23:0] c);
    return {c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] unpack28(input logic [27:0] p);
    return {p[27:24], p[11:8], p[23:16], p[7:0]};
  endfunction

  function automatic int ones28(input logic [27:0] p);
    int n = 0;
    for (int i = 0; i < 28; i++) n += int'(p[i]);
    return n;
  endfunction

  // Expected verdict per R3..R8.
  task automatic model(input logic [23:0] s, input logic [23:0] c,
                       output logic [1:0] est, output logic [8:0] eby, output logic [2:0] ebi);
    logic [27:0] syn;
    syn = pack28(s) ^ pack28(c);
    eby = '0; ebi = '0;
    if (syn == 0) est = 2'b00;
    else if (ones28(syn) == 12) begin est = 2'b01; eby = syn[27:19]; ebi = syn[18:16]; end
    else if (ones28(syn) == 1) est = 2'b10;
    else if (pack28(s) == 28'h0FFF0FFF && pack28(c) == 0) est = 2'b00;
    else est = 2'b11;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic apply(input logic [23:0] s, input logic [23:0] c);
    @(negedge clk);
    stored_i = s; computed_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_and_check(input string tag, input logic [23:0] s, input logic [23:0] c);
    logic [1:0] es; logic [8:0] eb; logic [2:0] ei;
    model(s, c, es, eb, ei);
    apply(s, c);
    chk({tag, " R2 valid"}, 32'(v_o), 32'd1);
    chk({tag, " status"}, 32'(st_o), 32'(es));
    chk({tag, " byte R8"}, 32'(byte_o), 32'(eb));
    chk({tag, " bit R8"}, 32'(bit_o), 32'(ei));
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(v_o), 0);
    chk("R1 status", 32'(st_o), 0);
    chk("R1 loc", {20'd0, byte_o, bit_o}, 0);
  endtask

  task automatic t_clean();
    run_and_check("R3 equal a", 24'h123456, 24'h123456);
    chk("R3 status clean", 32'(st_o), 32'd0);
    @(negedge clk);
    chk("R2 pulse ends", 32'(v_o), 0);
    run_and_check("R3 equal b", 24'hA5C30F, 24'hA5C30F);
  endtask

  task automatic t_data(input logic [8:0] b, input logic [2:0] k, input logic [23:0] base);
    logic [11:0] l; logic [27:0] syn;
    l = {b, k};
    syn = {l, 4'h0, ~l};
    run_and_check("R4 data flip", base, base ^ unpack28(syn));
    chk("R4 status fixable", 32'(st_o), 32'd1);
    chk("R4 byte", 32'(byte_o), 32'(b));
    chk("R4 bit", 32'(bit_o), 32'(k));
  endtask

  task automatic t_codebit(input int pos);
    logic [23:0] base = 24'h5A3C77;
    run_and_check("R5 code bit", base, base ^ (24'd1 << pos));
    chk("R5 status code bad", 32'(st_o), 32'd2);
  endtask

  task automatic t_erased();
    run_and_check("R6 erased", 24'hFFFFFF, 24'h000000);
    chk("R6 status clean", 32'(st_o), 32'd0);
    run_and_check("R7 swapped erased", 24'h000000, 24'hFFFFFF);
    chk("R7 status fatal", 32'(st_o), 32'd3);
  endtask

  task automatic t_double();
    run_and_check("R7 two bits", 24'h0F0F0F, 24'h0F0F0F ^ 24'h00081);
    chk("R7 status fatal", 32'(st_o), 32'd3);
    run_and_check("R7 five bits", 24'h000000, 24'h01F000);
  endtask

  task automatic t_hold();
    logic [11:0] l;
    t_data(9'd77, 3'd6, 24'h000000);
    l = {byte_o, bit_o};
    @(negedge clk);
    stored_i = 24'hFFFFFF; computed_i = 24'h000001;
    repeat (3) @(negedge clk);
    chk("R9 no pulse", 32'(v_o), 0);
    chk("R9 status held", 32'(st_o), 32'd1);
    chk("R9 loc held", 32'({byte_o, bit_o}), 32'(l));
  endtask

  task automatic t_b2b();
    @(negedge clk);
    stored_i = 24'h111111; computed_i = 24'h111111; start_i = 1'b1;
    @(negedge clk);
    chk("R2 b2b first valid", 32'(v_o), 1);
    chk("R2 b2b first status", 32'(st_o), 0);
    stored_i = 24'h222222; computed_i = 24'h222223;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 b2b second valid", 32'(v_o), 1);
    chk("R2 b2b second status R5", 32'(st_o), 2);
    @(negedge clk);
    chk("R2 b2b idle", 32'(v_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean();
    t_data(9'd0,   3'd0, 24'h000000);
    t_data(9'd511, 3'd7, 24'hC0FFEE);
    t_data(9'd300, 3'd5, 24'h13579B);
    t_codebit(0);
    t_codebit(13);
    t_codebit(23);
    t_erased();
    t_double();
    t_hold();
    t_b2b();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule